// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block prepares the second operand of a 32-bit datapath. It takes a data word, a shift type, a shift amount and the incoming carry flag, and returns the shifted word together with the carry that the shift produces. The amount comes from one of two sources. One is a 5-bit immediate field. The other is an 8-bit amount that has already been taken from the low byte of a register. A select input chooses between them.

The two sources treat edge values differently. With an immediate, a zero field is reinterpreted: it means a shift of 32 for the two right shifts, and it selects rotate-right-extended (RRX) for the rotate type. With a register amount, zero always means "no shift", and amounts up to 255 are honoured. This gives the saturating behaviour of shifts by 32 and beyond.

The shift itself is combinational. It uses a logarithmic rotator followed by fill masks. The result and carry pass through an output register stage, which a parameter can remove. When the stage is present it loads on a clock enable and clears on reset.

Top module: `operand_shifter`

## Requirements
- R1: Shift type encoding is 00 LSL, 01 LSR, 10 ASR, 11 ROR. An immediate LSL by 1..31 gives the word shifted left with zero fill, and the carry is bit (32 - n) of the input. An immediate LSL by 0 returns the input word unchanged and passes carry_i through.
- R2: An immediate LSR or ASR by 1..31 shifts right, with zero fill for LSR and sign fill for ASR. The carry is input bit (n - 1). An immediate field of 0 acts as a shift of 32: LSR gives zero, ASR gives every bit equal to bit 31, and the carry is bit 31 in both cases.
- R3: An immediate ROR by 1..31 rotates right, and the carry is the new bit 31. An immediate ROR with a field of 0 is RRX: the result is {carry_i, input[31:1]} and the carry is input bit 0.
- R4: With amt_sel_i = 1 the amount is the 8-bit amt_reg_i. Amounts 1..31 shift exactly like the same immediate amounts, and the carry is the last bit shifted out.
- R5: A register amount of 0 returns the input word unchanged with carry_i passed through, for every shift type.
- R6: A register LSL or LSR by exactly 32 gives zero. The carry is input bit 0 for LSL and input bit 31 for LSR.
- R7: A register LSL or LSR by 33..255 gives zero with a carry of 0.
- R8: A register ASR by 32..255 fills every bit with input bit 31, and the carry equals input bit 31.
- R9: A register ROR rotates right by the amount modulo 32. For a nonzero multiple of 32, the word is unchanged and the carry is input bit 31. Otherwise the carry is the new bit 31.
- R10: With the output stage present, the result and carry appear one clock after they are presented with en_i = 1. They hold while en_i = 0, and both are 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Load enable for the output stage |
| opnd_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift type (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| amt_sel_i | input | 1 | Amount source: 0 immediate, 1 register |
| amt_imm_i | input | 5 | Immediate amount field |
| amt_reg_i | input | 8 | Register amount (low byte of source register) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
On every enabled cycle, the assertions check the passthrough rule for a zero amount, the RRX bit arrangement, sign saturation for large arithmetic shifts, the zero result for logical shifts beyond 32, and the hold of the output stage while disabled. The following can only be shown by the bench's scenarios, by comparison against an independently computed reference: the exact bit placement and last-out carry for in-range amounts, the modulo behaviour of register rotates, the reinterpretation of a zero immediate for the right shifts, and the exact-32 boundary for each shift type.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  shift_kind_e      kind,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [AMT_W-1:0] reg_amt,
  output logic [AMT_W-1:0] amt,
  output logic             rrx
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  always_comb begin
    amt = '0;
    rrx = 1'b0;
    if (use_reg) begin
      amt = reg_amt;
    end else if (imm == '0) begin
      unique case (kind)
        SK_LSR, SK_ASR: amt = FULL;
        SK_ROR:         rrx = 1'b1;
        default:        amt = '0;
      endcase
    end else begin
      amt = AMT_W'(imm);
    end
  end
endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] k,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int C = 1 << s;
    assign stg[s+1] = k[s] ? {stg[s][C-1:0], stg[s][W-1:C]} : stg[s];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     value,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             rrx,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int AW = $clog2(W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic [AW-1:0] r;
  logic [AW-1:0] r_neg;
  logic [AW-1:0] idx_r;
  logic [AW-1:0] k_rot;
  logic [W-1:0]  rot;
  logic [W-1:0]  lo_mask;
  logic [W-1:0]  hi_mask;
  logic          sign;

  assign r       = amt[AW-1:0];
  assign r_neg   = ~r + 1'b1;
  assign idx_r   = r - 1'b1;
  assign k_rot   = (kind == SK_LSL) ? r_neg : r;
  assign lo_mask = {W{1'b1}} >> r;
  assign hi_mask = {W{1'b1}} << r;
  assign sign    = value[W-1];

  shf_rotator #(.W(W), .AW(AW)) u_rot (
    .din  (value),
    .k    (k_rot),
    .dout (rot)
  );

  always_comb begin
    res  = value;
    cout = cin;
    if (rrx) begin
      res  = {cin, value[W-1:1]};
      cout = value[0];
    end else if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          if (amt > FULL) begin
            res = '0; cout = 1'b0;
          end else if (amt == FULL) begin
            res = '0; cout = value[0];
          end else begin
            res = rot & hi_mask; cout = value[r_neg];
          end
        end
        SK_LSR: begin
          if (amt > FULL) begin
            res = '0; cout = 1'b0;
          end else if (amt == FULL) begin
            res = '0; cout = sign;
          end else begin
            res = rot & lo_mask; cout = value[idx_r];
          end
        end
        SK_ASR: begin
          if (amt >= FULL) begin
            res = {W{sign}}; cout = sign;
          end else begin
            res  = (rot & lo_mask) | (~lo_mask & {W{sign}});
            cout = value[idx_r];
          end
        end
        default: begin
          res  = rot;
          cout = value[idx_r];
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_res,
  input  logic         d_c,
  output logic [W-1:0] q_res,
  output logic         q_c
);
  logic [W-1:0] nxt_res;
  logic         nxt_c;

  always_comb begin
    nxt_res = q_res;
    nxt_c   = q_c;
    if (en) begin
      nxt_res = d_res;
      nxt_c   = d_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_res <= '0;
      q_c   <= 1'b0;
    end else begin
      q_res <= nxt_res;
      q_c   <= nxt_c;
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shf_pkg::*;
#(
  parameter int W       = 32,
  parameter int IMM_W   = 5,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [1:0]       kind_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] amt_imm_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  shift_kind_e      kind;
  logic [AMT_W-1:0] dec_amt;
  logic             dec_rrx;
  logic [W-1:0]     sh_res;
  logic             sh_c;

  assign kind = shift_kind_e'(kind_i);

  shf_amt_decode #(.W(W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_dec (
    .kind    (kind),
    .use_reg (amt_sel_i),
    .imm     (amt_imm_i),
    .reg_amt (amt_reg_i),
    .amt     (dec_amt),
    .rrx     (dec_rrx)
  );

  shf_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .value (opnd_i),
    .kind  (kind),
    .amt   (dec_amt),
    .rrx   (dec_rrx),
    .cin   (carry_i),
    .res   (sh_res),
    .cout  (sh_c)
  );

  if (REG_OUT) begin : g_reg
    shf_out_stage #(.W(W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_i),
      .d_res (sh_res),
      .d_c   (sh_c),
      .q_res (result_o),
      .q_c   (carry_o)
    );

    // R10: disabled stage keeps its contents
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> ($stable(result_o) && $stable(carry_o)));

    // R5 / R1: zero effective amount passes word and carry through
    assert_zero_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !dec_rrx && dec_amt == '0) |=>
        (result_o == $past(opnd_i) && carry_o == $past(carry_i)));

    // R3: RRX arrangement
    assert_rrx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && dec_rrx) |=>
        (result_o == {$past(carry_i), $past(opnd_i[W-1:1])} &&
         carry_o == $past(opnd_i[0])));

    // R8: arithmetic saturation
    assert_asr_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && kind == SK_ASR && dec_amt >= FULL) |=>
        (result_o == {W{$past(opnd_i[W-1])}} && carry_o == $past(opnd_i[W-1])));

    // R7: logical shifts past the word width clear everything
    assert_big_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (kind == SK_LSL || kind == SK_LSR) && dec_amt > FULL) |=>
        (result_o == '0 && !carry_o));
  end else begin : g_comb
    assign result_o = sh_res;
    assign carry_o  = sh_c;
  end
endmodule

// File: tb/tb_operand_shifter.sv
`timescale 1ns/1ps
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [31:0] opnd_i;
  logic [1:0]  kind_i;
  logic        amt_sel_i;
  logic [4:0]  amt_imm_i;
  logic [7:0]  amt_reg_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  operand_shifter dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .opnd_i(opnd_i), .kind_i(kind_i),
    .amt_sel_i(amt_sel_i), .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i),
    .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  // Reference model from the requirements: {carry, result}
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
      input logic ur, input logic [4:0] imm, input logic [7:0] ra, input logic cin);
    int a;
    logic [31:0] res;
    logic c;
    a = ur ? int'(ra) : int'(imm);
    if (!ur && imm == 5'd0 && k == 2'b11) return {v[0], cin, v[31:1]};
    if (!ur && imm == 5'd0 && (k == 2'b01 || k == 2'b10)) a = 32;
    if (a == 0) return {cin, v};
    res = '0;
    c = 1'b0;
    for (int i = 0; i < 32; i++) begin
      case (k)
        2'b00: res[i] = (i - a >= 0) ? v[i-a] : 1'b0;
        2'b01: res[i] = (i + a < 32) ? v[i+a] : 1'b0;
        2'b10: res[i] = (i + a < 32) ? v[i+a] : v[31];
        default: res[i] = v[(i + a) % 32];
      endcase
    end
    case (k)
      2'b00: c = (a <= 32) ? v[32-a] : 1'b0;
      2'b01: c = (a <= 32) ? v[a-1] : 1'b0;
      2'b10: c = (a <= 32) ? v[a-1] : v[31];
      default: c = res[31];
    endcase
    return {c, res};
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic ur,
      input logic [4:0] imm, input logic [7:0] ra);
    if (!ur) begin
      if (k == 2'b00) return "R1";
      if (k == 2'b11) return "R3";
      return "R2";
    end
    if (ra == 8'd0) return "R5";
    if (k == 2'b11) return "R9";
    if (k == 2'b10 && ra >= 8'd32) return "R8";
    if (ra == 8'd32) return "R6";
    if (ra > 8'd32) return "R7";
    return "R4";
  endfunction

  task automatic run_case(input logic [31:0] v, input logic [1:0] k, input logic ur,
      input logic [4:0] imm, input logic [7:0] ra, input logic cin);
    logic [32:0] exp;
    string tg;
    exp = ref_shift(v, k, ur, imm, ra, cin);
    tg = tag_of(k, ur, imm, ra);
    @(negedge clk);
    en_i = 1'b1; opnd_i = v; kind_i = k; amt_sel_i = ur;
    amt_imm_i = imm; amt_reg_i = ra; carry_i = cin;
    @(negedge clk);
    checks++;
    if ({carry_o, result_o} !== exp) begin
      errors++;
      $display("FAIL %s: kind=%0d sel=%0d imm=%0d reg=%0d actual c=%0b r=%h expected c=%0b r=%h",
               tg, k, ur, imm, ra, carry_o, result_o, exp[32], exp[31:0]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held;
    logic        heldc;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en_i = 1'b0; opnd_i = '0; kind_i = '0; amt_sel_i = 1'b0;
    amt_imm_i = '0; amt_reg_i = '0; carry_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual c=%0b r=%h expected c=0 r=0", carry_o, result_o);
    end
    rst_n = 1'b1;

    // R1 directed
    run_case(32'h8000_0001, 2'b00, 1'b0, 5'd0,  8'd0, 1'b1);
    run_case(32'h8000_0001, 2'b00, 1'b0, 5'd1,  8'd0, 1'b0);
    run_case(32'h0000_0003, 2'b00, 1'b0, 5'd31, 8'd0, 1'b0);
    // R2 directed
    run_case(32'hF000_0001, 2'b01, 1'b0, 5'd1,  8'd0, 1'b0);
    run_case(32'h8000_0000, 2'b01, 1'b0, 5'd0,  8'd0, 1'b0);
    run_case(32'h8000_0000, 2'b10, 1'b0, 5'd0,  8'd0, 1'b0);
    run_case(32'h8765_4321, 2'b10, 1'b0, 5'd4,  8'd0, 1'b0);
    // R3 directed
    run_case(32'h0000_0001, 2'b11, 1'b0, 5'd0,  8'd0, 1'b1);
    run_case(32'h0000_0002, 2'b11, 1'b0, 5'd0,  8'd0, 1'b0);
    run_case(32'h1234_5678, 2'b11, 1'b0, 5'd8,  8'd0, 1'b1);
    // R4 directed
    run_case(32'hA5A5_0F0F, 2'b01, 1'b1, 5'd0,  8'd7, 1'b0);
    run_case(32'hA5A5_0F0F, 2'b00, 1'b1, 5'd0,  8'd31, 1'b1);
    // R5 directed
    for (int k = 0; k < 4; k++) run_case(32'hDEAD_BEEF, 2'(k), 1'b1, 5'd0, 8'd0, 1'b1);
    // R6 directed
    run_case(32'h8000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0);
    run_case(32'h8000_0000, 2'b01, 1'b1, 5'd0, 8'd32, 1'b0);
    // R7 directed
    run_case(32'hFFFF_FFFF, 2'b00, 1'b1, 5'd0, 8'd33,  1'b1);
    run_case(32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd255, 1'b1);
    // R8 directed
    run_case(32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd32,  1'b0);
    run_case(32'h7FFF_FFFF, 2'b10, 1'b1, 5'd0, 8'd200, 1'b1);
    // R9 directed
    run_case(32'h8000_0001, 2'b11, 1'b1, 5'd0, 8'd64, 1'b0);
    run_case(32'h0000_0001, 2'b11, 1'b1, 5'd0, 8'd32, 1'b0);
    run_case(32'h0000_0010, 2'b11, 1'b1, 5'd0, 8'd37, 1'b0);

    // R10 hold with enable low
    run_case(32'h0F0F_0F0F, 2'b00, 1'b0, 5'd4, 8'd0, 1'b0);
    held = result_o; heldc = carry_o;
    @(negedge clk);
    en_i = 1'b0; opnd_i = 32'hFFFF_FFFF; kind_i = 2'b01; amt_imm_i = 5'd3; carry_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (result_o !== held || carry_o !== heldc) begin
      errors++;
      $display("FAIL R10 hold: actual c=%0b r=%h expected c=%0b r=%h",
               carry_o, result_o, heldc, held);
    end

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] v;
      logic [7:0]  ra;
      logic [4:0]  im;
      v  = $urandom;
      im = 5'($urandom_range(0, 31));
      case ($urandom_range(0, 3))
        0: ra = 8'($urandom_range(30, 34));
        1: ra = 8'(32 * $urandom_range(0, 7));
        default: ra = 8'($urandom_range(0, 255));
      endcase
      if ($urandom_range(0, 3) == 0) im = 5'd0;
      run_case(v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), im, ra,
               1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule